// File: doc/BRIEF.md
# Segmented Three-Axis Thermometer Decoder

This block is the digital front-end of a 12-bit segmented current-steering converter. A 12-bit code arrives every clock. Its upper nine bits select how many of 511 equal unary cells are switched on. Its lower three bits drive binary-weighted cells directly. The nine unary bits split into three 3-bit fields: column, row and height. Each field feeds its own small binary-to-thermometer decoder, so only 21 decoded lines fan out across the array instead of the 46 that a column-plus-row split would need. The per-cell logic then combines those lines into one enable per cell.

The block is fully pipelined and accepts a new code every cycle. Both the unary enables and the binary enables come out of registers. They share one fixed latency, so every switch control changes on the same clock edge. The binary bits travel through a delay line of the same depth as the decode pipeline.

Top module: `seg3d_decoder`

## Requirements
- R1: While `rstN` is low, `unaryEn` and `binEn` are all zero, whatever `inCode` holds.
- R2: A code sampled on a rising clock edge appears on both outputs after the third rising edge, counted from and including that edge. A new code is accepted on every edge.
- R3: The number of ones in `unaryEn` equals M, where M = `inCode[11:3]` (0 to 511) of the code the outputs belong to.
- R4: `unaryEn[i]` is 1 exactly when i < M. Cell i sits at height h = i/64, row r = (i/8)%8 and column c = i%8. Height is taken from `inCode[11:9]`, row from `inCode[8:6]` and column from `inCode[5:3]`.
- R5: `binEn` equals `inCode[2:0]` of the same code, with the same latency as `unaryEn`.
- R6: For M = 0 every unary enable is 0. For M = 511 all 511 enables are 1, including the top cell `unaryEn[510]`.
- R7: Back-to-back codes whose unary value carries across a column or row boundary (for example 63 to 64, or 447 to 448) each produce their own exact thermometer pattern in consecutive cycles, with no mixing between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inCode | input | 12 | Converter code: bits 11:3 unary value, bits 2:0 binary part |
| unaryEn | output | 511 | Registered unary cell enables, thermometer ordered |
| binEn | output | 3 | Registered binary cell enables, delay-matched |

## Verification
Every result of this block is due a fixed three rising edges after its code is sampled. This holds for the unary pattern, the enable count and the binary bits alike. The bench drives each code just after a falling edge and pushes it into a queue that was pre-filled with three reset-state zeros. On every later falling edge it pops the oldest entry and compares both outputs against the value computed from that entry, so each comparison lands on the cycle in which its code must be visible. The checker uses a saturating post-reset counter so that its three-cycle look-back never reaches into reset.

// File: rtl/seg3d_pkg.sv
package seg3d_pkg;
  localparam int GRP_BITS     = 3;
  localparam int GRP_COUNT    = 3;
  localparam int BIN_BITS     = 3;
  localparam int GRP_LEVELS   = 1 << GRP_BITS;
  localparam int GRP_LINES    = GRP_LEVELS - 1;
  localparam int THERM_BITS   = GRP_BITS * GRP_COUNT;
  localparam int CODE_BITS    = THERM_BITS + BIN_BITS;
  localparam int CELL_COUNT   = (1 << THERM_BITS) - 1;
  localparam int PIPE_LATENCY = 3;

  // Decoded lines of one axis: above[k] = value > k, equal[k] = value == k
  typedef struct packed {
    logic [GRP_LINES-1:0]  above;
    logic [GRP_LEVELS-1:0] equal;
  } grpLines_t;
endpackage

// File: rtl/seg3d_therm.sv
module seg3d_therm
  import seg3d_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [GRP_BITS-1:0] grpVal,
  output grpLines_t           linesQ
);
  grpLines_t linesD;

  // binary-to-thermometer lines
  for (genvar k = 0; k < GRP_LINES; k++) begin : g_above
    assign linesD.above[k] = (grpVal > GRP_BITS'(k));
  end

  // one-hot equality terms derived only from adjacent thermometer lines
  assign linesD.equal[0] = ~linesD.above[0];
  for (genvar k = 1; k < GRP_LINES; k++) begin : g_equal
    assign linesD.equal[k] = linesD.above[k-1] & ~linesD.above[k];
  end
  assign linesD.equal[GRP_LEVELS-1] = linesD.above[GRP_LINES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) linesQ <= '0;
    else       linesQ <= linesD;
  end
endmodule

// File: rtl/seg3d_cells.sv
module seg3d_cells
  import seg3d_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  grpLines_t             colL,
  input  grpLines_t             rowL,
  input  grpLines_t             hgtL,
  output logic [CELL_COUNT-1:0] cellEnQ
);
  logic [GRP_LEVELS-1:0] colGt, rowGt, hgtGt;
  logic [CELL_COUNT-1:0] cellEnD;

  // top level of each axis is never exceeded
  assign colGt = {1'b0, colL.above};
  assign rowGt = {1'b0, rowL.above};
  assign hgtGt = {1'b0, hgtL.above};

  for (genvar idx = 0; idx < CELL_COUNT; idx++) begin : g_cell
    localparam int CX = idx % GRP_LEVELS;
    localparam int RX = (idx / GRP_LEVELS) % GRP_LEVELS;
    localparam int HX = idx / (GRP_LEVELS * GRP_LEVELS);
    assign cellEnD[idx] = hgtGt[HX] |
                          (hgtL.equal[HX] & (rowGt[RX] | (rowL.equal[RX] & colGt[CX])));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cellEnQ <= '0;
    else       cellEnQ <= cellEnD;
  end
endmodule

// File: rtl/seg3d_decoder.sv
module seg3d_decoder
  import seg3d_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CODE_BITS-1:0]  inCode,
  output logic [CELL_COUNT-1:0] unaryEn,
  output logic [BIN_BITS-1:0]   binEn
);
  logic [THERM_BITS-1:0] thermQ;
  grpLines_t             axisLines [GRP_COUNT];
  logic [BIN_BITS-1:0]   binPipe   [PIPE_LATENCY];

  // stage 1: capture unary field
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) thermQ <= '0;
    else       thermQ <= inCode[CODE_BITS-1:BIN_BITS];
  end

  // stage 2: one decoder per axis (0 column, 1 row, 2 height)
  for (genvar g = 0; g < GRP_COUNT; g++) begin : g_axis
    seg3d_therm u_therm (
      .clk    (clk),
      .rstN   (rstN),
      .grpVal (thermQ[g*GRP_BITS +: GRP_BITS]),
      .linesQ (axisLines[g])
    );
  end

  // stage 3: cell enables
  seg3d_cells u_cells (
    .clk     (clk),
    .rstN    (rstN),
    .colL    (axisLines[0]),
    .rowL    (axisLines[1]),
    .hgtL    (axisLines[2]),
    .cellEnQ (unaryEn)
  );

  // dummy delay line for the binary bits, depth matched to the decode pipe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < PIPE_LATENCY; s++) binPipe[s] <= '0;
    end else begin
      binPipe[0] <= inCode[BIN_BITS-1:0];
      for (int s = 1; s < PIPE_LATENCY; s++) binPipe[s] <= binPipe[s-1];
    end
  end

  assign binEn = binPipe[PIPE_LATENCY-1];
endmodule

// File: rtl/seg3d_decoder_checker.sv
module seg3d_decoder_checker
  import seg3d_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic [CODE_BITS-1:0]  inCode,
  input logic [CELL_COUNT-1:0] unaryEn,
  input logic [BIN_BITS-1:0]   binEn
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |-> (unaryEn == '0 && binEn == '0));

  p_cell_count_r3: assert property (@(posedge clk) disable iff (!rstN)
    sinceRst == 2'd3 |->
      $countones(unaryEn) == int'($past(inCode[CODE_BITS-1:BIN_BITS], 3)));

  p_therm_order_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({1'b0, unaryEn} + (CELL_COUNT+1)'(1)));

  p_bin_align_r5: assert property (@(posedge clk) disable iff (!rstN)
    sinceRst == 2'd3 |-> binEn == $past(inCode[BIN_BITS-1:0], 3));

  p_full_scale_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && $past(inCode[CODE_BITS-1:BIN_BITS], 3) == '1) |-> (&unaryEn));
endmodule

bind seg3d_decoder seg3d_decoder_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inCode  (inCode),
  .unaryEn (unaryEn),
  .binEn   (binEn)
);

// File: tb/seg3d_decoder_bench.sv
module seg3d_decoder_bench;
  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [11:0]   inCode = '0;
  logic [510:0]  unaryEn;
  logic [2:0]    binEn;

  int errors = 0;
  int checks = 0;
  logic [11:0] codeQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  seg3d_decoder u_seg3d_decoder (
    .clk(clk), .rstN(rstN), .inCode(inCode), .unaryEn(unaryEn), .binEn(binEn)
  );

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(input bit ok, input string req, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  // compare outputs with the oldest queued code, then drive a new one
  task automatic step(input logic [11:0] v, input string tag);
    logic [11:0]  old;
    string        otag;
    logic [510:0] ev;
    int           m, ones;
    @(negedge clk);
    old  = codeQ.pop_front();
    otag = tagQ.pop_front();
    m    = int'(old[11:3]);
    for (int i = 0; i < 511; i++) ev[i] = (i < m);
    ones = $countones(unaryEn);
    chk(unaryEn == ev, {"R4 R2 pattern ", otag}, $sformatf("%h", unaryEn), $sformatf("%h", ev));
    chk(ones == m, {"R3 count ", otag}, $sformatf("%0d", ones), $sformatf("%0d", m));
    chk(binEn == old[2:0], {"R5 binary ", otag}, $sformatf("%0d", binEn), $sformatf("%0d", old[2:0]));
    if (m == 0 || m == 511)
      chk(unaryEn[510] == (m == 511) && ones == m, "R6 extreme",
          $sformatf("top=%0b ones=%0d", unaryEn[510], ones), $sformatf("m=%0d", m));
    inCode = v;
    codeQ.push_back(v);
    tagQ.push_back(tag);
  endtask

  task automatic primeQueue();
    codeQ.delete(); tagQ.delete();
    for (int i = 0; i < 3; i++) begin codeQ.push_back('0); tagQ.push_back("R1 post-reset"); end
  endtask

  task automatic applyReset(input logic [11:0] held);
    @(negedge clk);
    rstN = 1'b0;
    inCode = held;
    #1;
    chk(unaryEn == '0 && binEn == '0, "R1 reset clear",
        $sformatf("ones=%0d bin=%0d", $countones(unaryEn), binEn), "0");
    @(negedge clk);
    chk(unaryEn == '0 && binEn == '0, "R1 reset hold",
        $sformatf("ones=%0d bin=%0d", $countones(unaryEn), binEn), "0");
    inCode = '0;
    @(negedge clk);
    rstN = 1'b1;
    primeQueue();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    report();
    $finish;
  end

  initial begin
    logic [11:0] lfsr;
    applyReset(12'hABC);

    // sweep every unary value with varied binary part
    for (int m = 0; m < 512; m++) step({m[8:0], m[2:0] ^ 3'b101}, "sweep");

    // full-scale alternation
    for (int i = 0; i < 16; i++) step(i[0] ? 12'hFFF : 12'h000, "R6 alternate");

    // carries across column and row boundaries, back to back (R7)
    step({9'd63, 3'd1}, "R7 carry");  step({9'd64, 3'd2}, "R7 carry");
    step({9'd447, 3'd3}, "R7 carry"); step({9'd448, 3'd4}, "R7 carry");
    step({9'd510, 3'd5}, "R7 carry"); step({9'd511, 3'd6}, "R7 carry");
    step({9'd7, 3'd7}, "R7 carry");   step({9'd8, 3'd0}, "R7 carry");
    step({9'd256, 3'd0}, "R7 carry"); step({9'd255, 3'd7}, "R7 carry");

    // pseudo-random codes
    lfsr = 12'h5A3;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[10:0], lfsr[11] ^ lfsr[10] ^ lfsr[9] ^ lfsr[3]};
      step(lfsr, "random");
    end
    for (int i = 0; i < 3; i++) step('0, "drain");

    // reset in mid-run with a busy input, then resume
    step(12'hFFF, "pre-reset");
    applyReset(12'h7F5);
    step({9'd300, 3'd3}, "after reset");
    for (int i = 0; i < 4; i++) step('0, "drain");

    report();
    $finish;
  end
endmodule